// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Controller

This block runs single accesses on an 8-bit asynchronous external memory port, such as a raw NAND flash, on behalf of an internal requester. A request carries a direction, a chip-select region, an address and write data. The block runs the access as three timed phases: setup, strobe and hold. It then keeps the port idle for a turnaround gap, and reports completion with a one-cycle done pulse that comes with the read data.

Each chip-select region has its own 32-bit timing word. The word gives separate setup, strobe and hold lengths for reads and for writes, plus the turnaround length. Every phase lasts its field value plus one clock cycle. When a request is accepted, the block latches the timing word, the address and the write data. Later changes to the timing word therefore only affect later accesses. The block also passes the device ready/busy pin through a two-flop synchronizer as a ready status bit.

Timing word layout, with bits high to low: [31:30] unused mode bits, [29:26] write setup, [25:20] write strobe, [19:17] write hold, [16:13] read setup, [12:7] read strobe, [6:4] read hold, [3:2] turnaround, [1:0] bus width code (0 = 8-bit, the only width supported).

Top module: `async_strobe_ctl`

## Requirements
- R1: After reset, all chip selects, the output enable and the write enable are high (inactive). The data drive enable and done are low, and req_ready is high.
- R2: Every region's timing word resets to 0x3FFFFFFC. A read with the reset timing therefore has 16 setup, 64 strobe and 8 hold cycles, followed by 4 turnaround cycles.
- R3: A request is accepted on a rising edge where req_valid and req_ready are both high. From the next cycle, chip select is low for (setup+1) + (strobe+1) + (hold+1) cycles. The strobe is preceded by exactly setup+1 cycles and followed by exactly hold+1 cycles. The read fields are bits [16:13], [12:7] and [6:4]; the write fields are bits [29:26], [25:20] and [19:17].
- R4: In a read, mem_oe_n is low only during the strobe phase and mem_we_n stays high. rdata equals the value on mem_din during the last strobe cycle. done is high for exactly one cycle: the cycle right after hold ends.
- R5: In a write, mem_we_n is low only during the strobe phase and mem_oe_n stays high. mem_dout_en is high, with mem_dout equal to the write data, in every cycle that chip select is low.
- R6: req_ready stays low for turnaround+1 cycles, counted from the done cycle inclusive. The turnaround field is bits [3:2].
- R7: Only the chip select of the requested region (index req_region) goes low. Each region uses its own timing word, written through cfg_we with cfg_sel selecting the region.
- R8: Bits [31:30] and [1:0] of a timing word have no effect on access timing.
- R9: A request presented while req_ready is low is ignored: no access is started for it.
- R10: dev_ready follows mem_rb (1 = ready) two clock edges later, and not after one edge.
- R11: Writing a region's timing word during an access to that region does not change the access in progress.
- R12: mem_addr equals the request address during every chip-select-low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_sel | input | RSW | Region whose timing word is written |
| cfg_wdata | input | 32 | Timing word value |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | RSW | Chip-select region of the request |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block idle, request may be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Data captured by the last read |
| dev_ready | output | 1 | Synchronized device ready status |
| mem_cs_n | output | NREG | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | AW | Address to the device |
| mem_dout | output | DW | Data to the device |
| mem_dout_en | output | 1 | Data drive enable |
| mem_din | input | DW | Data from the device |
| mem_rb | input | 1 | Device ready/busy pin, 1 = ready |

## Verification
After the accepting edge, chip select, the strobes and the drive enable change in the cycle that follows. The done pulse follows setup+1, strobe+1 and hold+1 cycles, and req_ready rises turnaround+1 cycles after that. The bench samples all outputs on the falling edge. It counts phase lengths cycle by cycle and compares them with values decoded from the timing word the bench itself wrote. The device model changes mem_din on every strobe cycle, so a read captured one cycle early or late gives a different byte. The ready status is checked one edge and two edges after the pin changes.

// File: rtl/async_strobe_ctl.sv
module async_strobe_ctl #(
  parameter int NREG = 4,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [31:0] RESET_CFG = 32'h3FFF_FFFC,
  localparam int RSW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [RSW-1:0]  cfg_sel,
  input  logic [31:0]     cfg_wdata,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [RSW-1:0]  req_region,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic            dev_ready,
  output logic [NREG-1:0] mem_cs_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_dout,
  output logic            mem_dout_en,
  input  logic [DW-1:0]   mem_din,
  input  logic            mem_rb
);
  localparam int SU_W = 4, ST_W = 6, HO_W = 3, TA_W = 2;
  localparam int WSU = 26, WST = 20, WHO = 17;
  localparam int RSU = 13, RST = 7, RHO = 4, TAL = 2;
  localparam int CW = ST_W;

  typedef enum logic [2:0] {IDLE, SETUP, STROBE, HOLD, TURN} phase_t;

  logic [29:2]    cfg_q [NREG];
  logic [29:2]    cur;
  logic           cur_wr;
  logic [RSW-1:0] cur_rs;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  phase_t         phase;
  logic [CW-1:0]  cnt;
  logic [1:0]     rb_q;
  logic           active, last;

  wire unused_cfg_bits = ^{cfg_wdata[31:30], cfg_wdata[1:0]};

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cfg_q[g] <= RESET_CFG[29:2];
      else if (cfg_we && cfg_sel == RSW'(g)) cfg_q[g] <= cfg_wdata[29:2];
  end

  wire [SU_W-1:0] su_len = cur_wr ? cur[WSU +: SU_W] : cur[RSU +: SU_W];
  wire [ST_W-1:0] st_len = cur_wr ? cur[WST +: ST_W] : cur[RST +: ST_W];
  wire [HO_W-1:0] ho_len = cur_wr ? cur[WHO +: HO_W] : cur[RHO +: HO_W];
  wire [TA_W-1:0] ta_len = cur[TAL +: TA_W];
  wire [29:2]     sel_cfg = cfg_q[req_region];

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= IDLE;
      cnt     <= '0;
      cur     <= '0;
      cur_wr  <= 1'b0;
      cur_rs  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        IDLE: if (req_valid) begin
          cur     <= sel_cfg;
          cur_wr  <= req_write;
          cur_rs  <= req_region;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= CW'(req_write ? sel_cfg[WSU +: SU_W] : sel_cfg[RSU +: SU_W]);
          phase   <= SETUP;
        end
        SETUP: if (last) begin
          phase <= STROBE;
          cnt   <= CW'(st_len);
        end else cnt <= cnt - 1'b1;
        STROBE: if (last) begin
          phase <= HOLD;
          cnt   <= CW'(ho_len);
          if (!cur_wr) rdata <= mem_din;
        end else cnt <= cnt - 1'b1;
        HOLD: if (last) begin
          phase <= TURN;
          cnt   <= CW'(ta_len);
          done  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        TURN: if (last) phase <= IDLE;
              else cnt <= cnt - 1'b1;
        default: phase <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rb_q <= '0;
    else rb_q <= {rb_q[0], mem_rb};

  assign dev_ready   = rb_q[1];
  assign req_ready   = (phase == IDLE);
  assign active      = (phase == SETUP) || (phase == STROBE) || (phase == HOLD);
  assign mem_oe_n    = !(phase == STROBE && !cur_wr);
  assign mem_we_n    = !(phase == STROBE && cur_wr);
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_dout_en = active && cur_wr;

  always_comb begin
    mem_cs_n = '1;
    if (active) mem_cs_n[cur_rs] = 1'b0;
  end

  p_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_no_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> &mem_cs_n);
  p_drive_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> !(&mem_cs_n));
  p_done_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&mem_cs_n && !req_ready));
  p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_cs_n) && $past(!(&mem_cs_n))) |-> $stable(mem_addr));
endmodule

// File: tb/async_strobe_ctl_test.sv
module async_strobe_ctl_test;
  localparam int NREG = 4, AW = 16, DW = 8, RSW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [RSW-1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [RSW-1:0] req_region = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, dev_ready, mem_oe_n, mem_we_n, mem_dout_en;
  logic [DW-1:0] rdata, mem_dout;
  logic [DW-1:0] mem_din = '0;
  logic [NREG-1:0] mem_cs_n;
  logic [AW-1:0] mem_addr;
  logic mem_rb = 1'b1;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  async_strobe_ctl #(.NREG(NREG), .AW(AW), .DW(DW)) uut (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .req_valid, .req_write,
    .req_region, .req_addr, .req_wdata, .req_ready, .done, .rdata, .dev_ready,
    .mem_cs_n, .mem_oe_n, .mem_we_n, .mem_addr, .mem_dout, .mem_dout_en,
    .mem_din, .mem_rb);

  // entry: wr, region, timing word, addr, data
  localparam logic [58:0] VEC [6] = '{
    {1'b0, 2'd0, {2'b00, 4'd1, 6'd3, 3'd1, 4'd1, 6'd5, 3'd1, 2'd3, 2'd0}, 16'h1234, 8'hA5},
    {1'b1, 2'd0, {2'b00, 4'd1, 6'd3, 3'd1, 4'd1, 6'd5, 3'd1, 2'd3, 2'd0}, 16'h0F0F, 8'h3C},
    {1'b0, 2'd1, 32'h0, 16'hBEEF, 8'h11},
    {1'b1, 2'd2, {2'b00, 4'd2, 6'd0, 3'd0, 4'd9, 6'd9, 3'd5, 2'd1, 2'd0}, 16'h8001, 8'hC3},
    {1'b0, 2'd1, {2'b11, 4'd7, 6'd7, 3'd7, 4'd2, 6'd4, 3'd2, 2'd2, 2'd3}, 16'h4242, 8'h70},
    {1'b1, 2'd3, {2'b00, 4'd15, 6'd63, 3'd7, 4'd0, 6'd0, 3'd0, 2'd3, 2'd0}, 16'hFFFF, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [RSW-1:0] rg, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = rg; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input bit wr, input logic [RSW-1:0] rg, input logic [31:0] cfg,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke,
                     input string tag);
    int s, st, h, t, su_c, st_c, ho_c, cs_c, t_c, bad_cs, bad_dir, bad_addr, bad_drv;
    bit seen_st, seen_done;
    logic [DW-1:0] idx;
    s  = wr ? int'(cfg[29:26]) : int'(cfg[16:13]);
    st = wr ? int'(cfg[25:20]) : int'(cfg[12:7]);
    h  = wr ? int'(cfg[19:17]) : int'(cfg[6:4]);
    t  = int'(cfg[3:2]);
    su_c = 0; st_c = 0; ho_c = 0; cs_c = 0; t_c = 0;
    bad_cs = 0; bad_dir = 0; bad_addr = 0; bad_drv = 0;
    seen_st = 0; seen_done = 0; idx = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_region = rg; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      cfg_we = 1'b1; cfg_sel = rg; cfg_wdata = 32'h0;
      req_valid = 1'b1; req_region = rg + 1'b1; req_write = !wr;
    end
    for (int i = 0; i < 400; i++) begin
      if (i == 1) begin cfg_we = 1'b0; req_valid = 1'b0; end
      if (!mem_oe_n) begin mem_din = d + idx; idx++; end
      for (int k = 0; k < NREG; k++)
        if (k != int'(rg) && !mem_cs_n[k]) bad_cs++;
      if (!mem_cs_n[rg]) begin
        cs_c++;
        if (mem_addr != a) bad_addr++;
        if (wr && !(mem_dout_en && mem_dout == d)) bad_drv++;
        if (!wr && mem_dout_en) bad_drv++;
        if (wr ? !mem_oe_n : !mem_we_n) bad_dir++;
        if (wr ? !mem_we_n : !mem_oe_n) begin st_c++; seen_st = 1; end
        else if (!seen_st) su_c++;
        else ho_c++;
      end else if (!mem_oe_n || !mem_we_n) bad_dir++;
      if (done) begin seen_done = 1; break; end
      @(negedge clk);
    end
    chk(seen_done, "R4", {tag, " done seen"}, int'(seen_done), 1);
    chk(su_c == s + 1, "R3", {tag, " setup cycles"}, su_c, s + 1);
    chk(st_c == st + 1, "R3", {tag, " strobe cycles"}, st_c, st + 1);
    chk(ho_c == h + 1, "R3", {tag, " hold cycles"}, ho_c, h + 1);
    chk(cs_c == s + st + h + 3, "R3", {tag, " cs cycles"}, cs_c, s + st + h + 3);
    chk(bad_cs == 0, "R7", {tag, " other cs low"}, bad_cs, 0);
    chk(bad_dir == 0, wr ? "R5" : "R4", {tag, " wrong strobe"}, bad_dir, 0);
    chk(bad_addr == 0, "R12", {tag, " address"}, bad_addr, 0);
    chk(bad_drv == 0, "R5", {tag, " data drive"}, bad_drv, 0);
    if (!wr) chk(rdata == DW'(d + st), "R4", {tag, " rdata"}, int'(rdata), int'(DW'(d + st)));
    t_c = 1;
    @(negedge clk);
    chk(!done, "R4", {tag, " done width"}, int'(done), 0);
    while (!req_ready && t_c < 100) begin t_c++; @(negedge clk); end
    chk(t_c == t + 1, "R6", {tag, " turnaround"}, t_c, t + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int idle_cs;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(&mem_cs_n, "R1", "cs after reset", int'(mem_cs_n), 15);
    chk(mem_oe_n && mem_we_n, "R1", "strobes after reset", int'({mem_oe_n, mem_we_n}), 3);
    chk(!mem_dout_en && !done, "R1", "drive/done after reset", int'({mem_dout_en, done}), 0);
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 default timing word on region 3
    run(1'b0, 2'd3, 32'h3FFF_FFFC, 16'h0042, 8'h20, 1'b0, "R2 reset timing");
    // table walk, R8 covered by entry 4
    foreach (VEC[n]) begin
      write_cfg(VEC[n][57:56], VEC[n][55:24]);
      run(VEC[n][58], VEC[n][57:56], VEC[n][55:24], VEC[n][23:8], VEC[n][7:0], 1'b0,
          $sformatf("vec%0d", n));
    end
    // R11 and R9: rewrite timing and present a request mid-access
    write_cfg(2'd0, VEC[0][55:24]);
    run(1'b0, 2'd0, VEC[0][55:24], 16'h5555, 8'h01, 1'b1, "R11 mid-access");
    idle_cs = 0;
    repeat (8) begin
      if (!(&mem_cs_n) || !req_ready) idle_cs++;
      @(negedge clk);
    end
    chk(idle_cs == 0, "R9", "ignored request", idle_cs, 0);
    // R11: zero word now in effect
    run(1'b0, 2'd0, 32'h0, 16'h5556, 8'h02, 1'b0, "R11 next access");
    // R10 ready synchronizer
    mem_rb = 1'b0;
    @(negedge clk);
    chk(dev_ready == 1'b1, "R10", "busy after one edge", int'(dev_ready), 1);
    @(negedge clk);
    chk(dev_ready == 1'b0, "R10", "busy after two edges", int'(dev_ready), 0);
    mem_rb = 1'b1;
    @(negedge clk);
    chk(dev_ready == 1'b0, "R10", "ready after one edge", int'(dev_ready), 0);
    @(negedge clk);
    chk(dev_ready == 1'b1, "R10", "ready after two edges", int'(dev_ready), 1);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule